// File: doc/BRIEF.md
# Command-Decoding SPI Slave with Frame Memory

This block is a mode-0 SPI slave that sits between a host controller and a radio core. Every transaction opens with a command byte. That byte selects one of three services. The first is a two-byte access to a 64-entry register space, which is reached through a simple read/write port. The second streams a whole frame, with a length prefix, into or out of a 128-byte on-chip memory. The third reads or writes that same memory from a start address that the host supplies, with the address advancing by one after each byte.

While the host shifts in its command, the block returns a status byte. A 2-bit mode input chooses what that byte carries. A frame read returns the stored length, the payload and then a link-quality byte. A frame write stores a new length and payload. Releasing select ends any transaction cleanly, and the next transaction starts again from its first byte. The SPI pins are sampled with the system clock, so SCLK must be several times slower than that clock.

Top module: `spi_fb_slave`

## Requirements
- R1: After reset MISO is low, no strobe is active and the stored frame length is 0. A frame read issued straight after reset returns 0x00 as the length byte, followed at once by the link-quality byte.
- R2: Bytes travel MSB first. MOSI is taken on the rising SCLK edge, and MISO changes only after a falling SCLK edge or the falling edge of select.
- R3: The first MISO byte of a transfer is set by the status mode, sampled when select falls: 0 returns 0x00, 1 returns the transceiver-state input, 2 returns the signal-strength input and 3 returns the interrupt-status input.
- R4: A command with bit7=1 and bit6=0 is a register read. Bits[5:0] are placed on the address port with a single-cycle read enable, and the returned data is sent as the second MISO byte.
- R5: A command with bit7=1 and bit6=1 is a register write. The second MOSI byte is written to address bits[5:0] with a single-cycle write enable. Any byte after the second causes no further strobe and returns 0x00.
- R6: A register read of address IRQ_REG_ADDR (default 0x0F) raises a one-cycle interrupt-read strobe. A read of any other address does not.
- R7: A command with bits[7:5]=011 is a frame write. The second MOSI byte becomes the stored length, and the payload bytes that follow are stored from memory address 0 upward.
- R8: A command with bits[7:5]=001 is a frame read. After the status byte, MISO returns the length, then that many payload bytes, then the link-quality byte, then 0x00 for any further byte.
- R9: Releasing select partway through a frame read changes nothing. The next frame read starts again at the length byte.
- R10: A command with bits[7:5]=010 is an addressed write. The second byte is the start address (low 7 bits). Each following byte is stored and the address then increments, wrapping from 0x7F to 0x00 without a violation pulse.
- R11: A command with bits[7:5]=000 is an addressed read. Data starts with the third MISO byte at the start address and increments from there. Address 0x00 holds payload byte 0, because the length byte cannot be reached this way.
- R12: In a frame write, each payload byte beyond 127 raises a one-cycle violation pulse and is discarded, leaving memory address 0x7F unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, low when deselected |
| stat_mode | input | 2 | Selects the first MISO byte |
| stat_trx | input | 8 | Transceiver-state byte |
| stat_rssi | input | 8 | Signal-strength byte |
| stat_irq | input | 8 | Interrupt-status byte |
| lqi_byte | input | 8 | Link-quality byte appended to frame reads |
| reg_rd_en | output | 1 | Register read enable, one cycle |
| reg_wr_en | output | 1 | Register write enable, one cycle |
| reg_addr | output | REG_AW | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data, combinational from reg_addr |
| irq_rd_strobe | output | 1 | Interrupt-status register was read |
| fb_violation | output | 1 | Frame write overran the memory |

## Verification
A byte finishes on a rising SCLK edge, which is seen one clock later. The register, memory and violation strobes fire on the clock after that, and the reply for the next byte is registered one clock later still. That reply reaches MISO one clock after the following falling edge is seen. The bench changes SCLK only every four clocks and reads MISO just before it raises SCLK, four clocks after the previous falling edge, so every reply is sampled at least two clocks after it is due. Strobe counters are updated on every clock and compared only after select has been released, once all pulses of a transfer have occurred.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_REG_RD,
        ACC_REG_WR,
        ACC_FR_RD,
        ACC_FR_WR,
        ACC_AD_RD,
        ACC_AD_WR
    } acc_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ARG  = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        byte_t trx;
        byte_t rssi;
        byte_t irq;
    } stat_src_t;

    // bit7 set: register space, bit6 = write; otherwise bits[6:5] pick buffer mode
    function automatic acc_e decode_cmd(byte_t c);
        if (c[7]) begin
            return c[6] ? ACC_REG_WR : ACC_REG_RD;
        end
        case (c[6:5])
            2'b01:   return ACC_FR_RD;
            2'b11:   return ACC_FR_WR;
            2'b10:   return ACC_AD_WR;
            default: return ACC_AD_RD;
        endcase
    endfunction

    function automatic byte_t pick_status(logic [1:0] mode, stat_src_t s);
        case (mode)
            2'd1:    return s.trx;
            2'd2:    return s.rssi;
            2'd3:    return s.irq;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/spi_fb_shift.sv
module spi_fb_shift
    import spi_fb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sclk,
    input  logic  cs_n,
    input  logic  mosi,
    input  byte_t status,
    input  byte_t next_byte,
    output logic  miso,
    output logic  sel_start,
    output logic  byte_done,
    output byte_t rx_byte
);

    localparam int CNT_W = $clog2(BYTE_W);

    logic                sclk_q;
    logic                cs_q;
    logic [CNT_W-1:0]    bit_cnt;
    logic [BYTE_W-2:0]   rx_sh;
    byte_t               tx_sh;
    logic                rise;
    logic                fall;

    assign sel_start = cs_q & ~cs_n;
    assign rise      = ~cs_n & sclk & ~sclk_q;
    assign fall      = ~cs_n & ~sclk & sclk_q;
    assign miso      = ~cs_n & tx_sh[BYTE_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= 1'b0;
            cs_q      <= 1'b1;
            bit_cnt   <= '0;
            rx_sh     <= '0;
            rx_byte   <= '0;
            byte_done <= 1'b0;
            tx_sh     <= '0;
        end else begin
            sclk_q    <= sclk;
            cs_q      <= cs_n;
            byte_done <= 1'b0;
            if (cs_n) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
            end else if (sel_start) begin
                bit_cnt <= '0;
                tx_sh   <= status;
            end else begin
                if (rise) begin
                    if (bit_cnt == CNT_W'(BYTE_W - 1)) begin
                        rx_byte   <= {rx_sh, mosi};
                        byte_done <= 1'b1;
                        bit_cnt   <= '0;
                    end else begin
                        rx_sh   <= {rx_sh[BYTE_W-3:0], mosi};
                        bit_cnt <= bit_cnt + CNT_W'(1);
                    end
                end
                if (fall) begin
                    // a falling edge with the counter at zero follows a completed byte
                    if (bit_cnt == '0) begin
                        tx_sh <= next_byte;
                    end else begin
                        tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                    end
                end
            end
        end
    end

endmodule

// File: rtl/spi_fb_mem.sv
module spi_fb_mem
    import spi_fb_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  byte_t         wdata,
    input  logic [AW-1:0] raddr,
    output byte_t         rdata,
    input  logic          len_we,
    input  logic [AW-1:0] len_d,
    output logic [AW-1:0] len_q
);

    byte_t mem_q [DEPTH];

    assign rdata = mem_q[raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= '0;
            end
            len_q <= '0;
        end else begin
            if (we) begin
                mem_q[waddr] <= wdata;
            end
            if (len_we) begin
                len_q <= len_d;
            end
        end
    end

endmodule

// File: rtl/spi_fb_ctrl.sv
module spi_fb_ctrl
    import spi_fb_pkg::*;
#(
    parameter int              DEPTH    = 128,
    parameter int              REG_AW   = 6,
    parameter logic [REG_AW-1:0] IRQ_ADDR = 6'h0F,
    parameter int              AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_start,
    input  logic              byte_done,
    input  byte_t             rx_byte,
    input  byte_t             reg_rdata,
    input  byte_t             lqi,
    input  byte_t             mem_rdata,
    input  logic [AW-1:0]     len_q,
    output byte_t             next_byte,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output byte_t             mem_wdata,
    output logic [AW-1:0]     mem_raddr,
    output logic              len_we,
    output logic [AW-1:0]     len_d,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_addr,
    output byte_t             reg_wdata,
    output logic              fb_violation,
    output logic              irq_rd_strobe
);

    localparam int              CNT_W   = AW + 1;
    localparam logic [CNT_W-1:0] MAX_PAY = CNT_W'(DEPTH - 1);

    phase_e              phase;
    acc_e                kind;
    acc_e                cmd_kind;
    logic [AW-1:0]       ptr;
    logic [CNT_W-1:0]    fcnt;
    logic [CNT_W-1:0]    len_ext;
    logic [REG_AW-1:0]   reg_addr_q;
    logic                fw_data;
    logic                fw_full;
    logic                aw_data;

    assign cmd_kind = decode_cmd(rx_byte);
    assign len_ext  = {1'b0, len_q};

    assign reg_rd_en     = byte_done && phase == PH_CMD && cmd_kind == ACC_REG_RD;
    assign reg_wr_en     = byte_done && phase == PH_ARG && kind == ACC_REG_WR;
    assign reg_addr      = (phase == PH_CMD) ? rx_byte[REG_AW-1:0] : reg_addr_q;
    assign reg_wdata     = rx_byte;
    assign irq_rd_strobe = reg_rd_en && (reg_addr == IRQ_ADDR);

    assign len_we  = byte_done && phase == PH_ARG && kind == ACC_FR_WR;
    assign len_d   = rx_byte[AW-1:0];
    assign fw_data = byte_done && phase == PH_DATA && kind == ACC_FR_WR;
    assign fw_full = fcnt >= MAX_PAY;
    assign aw_data = byte_done && phase == PH_DATA && kind == ACC_AD_WR;

    assign fb_violation = fw_data && fw_full;
    assign mem_we       = (fw_data && !fw_full) || aw_data;
    assign mem_waddr    = (kind == ACC_FR_WR) ? fcnt[AW-1:0] : ptr;
    assign mem_wdata    = rx_byte;

    always_comb begin
        if (phase == PH_ARG && kind == ACC_AD_RD) begin
            mem_raddr = rx_byte[AW-1:0];
        end else if (kind == ACC_FR_RD) begin
            mem_raddr = fcnt[AW-1:0];
        end else begin
            mem_raddr = ptr;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sel_start) begin
            phase      <= PH_CMD;
            kind       <= ACC_NONE;
            ptr        <= '0;
            fcnt       <= '0;
            next_byte  <= '0;
            reg_addr_q <= '0;
        end else if (byte_done) begin
            case (phase)
                PH_CMD: begin
                    kind       <= cmd_kind;
                    phase      <= PH_ARG;
                    reg_addr_q <= rx_byte[REG_AW-1:0];
                    fcnt       <= '0;
                    if (cmd_kind == ACC_REG_RD) begin
                        next_byte <= reg_rdata;
                    end else if (cmd_kind == ACC_FR_RD) begin
                        next_byte <= byte_t'(len_ext);
                    end else begin
                        next_byte <= '0;
                    end
                end
                default: begin
                    phase <= PH_DATA;
                    if (kind == ACC_FR_RD) begin
                        if (fcnt < len_ext) begin
                            next_byte <= mem_rdata;
                            fcnt      <= fcnt + CNT_W'(1);
                        end else if (fcnt == len_ext) begin
                            next_byte <= lqi;
                            fcnt      <= fcnt + CNT_W'(1);
                        end else begin
                            next_byte <= '0;
                        end
                    end else if (kind == ACC_AD_RD) begin
                        next_byte <= mem_rdata;
                        ptr       <= ((phase == PH_ARG) ? rx_byte[AW-1:0] : ptr) + AW'(1);
                    end else if (kind == ACC_AD_WR) begin
                        next_byte <= '0;
                        ptr       <= (phase == PH_ARG) ? rx_byte[AW-1:0] : ptr + AW'(1);
                    end else if (kind == ACC_FR_WR) begin
                        next_byte <= '0;
                        if (phase == PH_DATA && !fw_full) begin
                            fcnt <= fcnt + CNT_W'(1);
                        end
                    end else begin
                        next_byte <= '0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/spi_fb_slave.sv
module spi_fb_slave
    import spi_fb_pkg::*;
#(
    parameter int                DEPTH        = 128,
    parameter int                REG_AW       = 6,
    parameter logic [REG_AW-1:0] IRQ_REG_ADDR = 6'h0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic [1:0]        stat_mode,
    input  logic [7:0]        stat_trx,
    input  logic [7:0]        stat_rssi,
    input  logic [7:0]        stat_irq,
    input  logic [7:0]        lqi_byte,
    output logic              reg_rd_en,
    output logic              reg_wr_en,
    output logic [REG_AW-1:0] reg_addr,
    output logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_rdata,
    output logic              irq_rd_strobe,
    output logic              fb_violation
);

    localparam int AW = $clog2(DEPTH);

    stat_src_t     stat_src;
    byte_t         status;
    byte_t         next_byte;
    byte_t         rx_byte;
    logic          sel_start;
    logic          byte_done;
    logic          mem_we;
    logic [AW-1:0] mem_waddr;
    byte_t         mem_wdata;
    logic [AW-1:0] mem_raddr;
    byte_t         mem_rdata;
    logic          len_we;
    logic [AW-1:0] len_d;
    logic [AW-1:0] len_q;

    assign stat_src = '{trx: stat_trx, rssi: stat_rssi, irq: stat_irq};
    assign status   = pick_status(stat_mode, stat_src);

    spi_fb_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .sclk      (spi_sclk),
        .cs_n      (spi_cs_n),
        .mosi      (spi_mosi),
        .status    (status),
        .next_byte (next_byte),
        .miso      (spi_miso),
        .sel_start (sel_start),
        .byte_done (byte_done),
        .rx_byte   (rx_byte)
    );

    spi_fb_ctrl #(
        .DEPTH    (DEPTH),
        .REG_AW   (REG_AW),
        .IRQ_ADDR (IRQ_REG_ADDR)
    ) u_ctrl (
        .clk           (clk),
        .rst           (rst),
        .sel_start     (sel_start),
        .byte_done     (byte_done),
        .rx_byte       (rx_byte),
        .reg_rdata     (reg_rdata),
        .lqi           (lqi_byte),
        .mem_rdata     (mem_rdata),
        .len_q         (len_q),
        .next_byte     (next_byte),
        .mem_we        (mem_we),
        .mem_waddr     (mem_waddr),
        .mem_wdata     (mem_wdata),
        .mem_raddr     (mem_raddr),
        .len_we        (len_we),
        .len_d         (len_d),
        .reg_rd_en     (reg_rd_en),
        .reg_wr_en     (reg_wr_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .fb_violation  (fb_violation),
        .irq_rd_strobe (irq_rd_strobe)
    );

    spi_fb_mem #(
        .DEPTH (DEPTH)
    ) u_mem (
        .clk    (clk),
        .rst    (rst),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .raddr  (mem_raddr),
        .rdata  (mem_rdata),
        .len_we (len_we),
        .len_d  (len_d),
        .len_q  (len_q)
    );

endmodule

// File: rtl/spi_fb_slave_chk.sv
module spi_fb_slave_chk (
    input logic clk,
    input logic rst,
    input logic spi_sclk,
    input logic spi_cs_n,
    input logic spi_miso,
    input logic reg_rd_en,
    input logic reg_wr_en,
    input logic irq_rd_strobe,
    input logic fb_violation
);

    // R2: MISO only moves after a falling SCLK edge or a select fall
    p_miso_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!spi_cs_n && !$past(spi_cs_n) && !$past(spi_cs_n, 2)
         && !($past(spi_sclk, 2) && !$past(spi_sclk)))
        |-> $stable(spi_miso));

    // R4: a read enable and a write enable never coincide
    p_rd_wr_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd_en && reg_wr_en));

    // R5: write enable lasts a single cycle
    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        reg_wr_en |=> !reg_wr_en);

    // R6: interrupt-read strobe lasts a single cycle
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        irq_rd_strobe |=> !irq_rd_strobe);

    // R12: violation pulse lasts a single cycle
    p_viol_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        fb_violation |=> !fb_violation);

    // R1: with select held high no strobe fires
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (spi_cs_n && $past(spi_cs_n))
        |-> !(reg_rd_en || reg_wr_en || fb_violation || irq_rd_strobe));

endmodule

bind spi_fb_slave spi_fb_slave_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .spi_sclk      (spi_sclk),
    .spi_cs_n      (spi_cs_n),
    .spi_miso      (spi_miso),
    .reg_rd_en     (reg_rd_en),
    .reg_wr_en     (reg_wr_en),
    .irq_rd_strobe (irq_rd_strobe),
    .fb_violation  (fb_violation)
);

// File: tb/spi_fb_slave_tb.sv
module spi_fb_slave_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       sclk, cs_n, mosi;
    logic       miso;
    logic [1:0] stat_mode;
    logic [7:0] stat_trx, stat_rssi, stat_irq, lqi;
    logic       reg_rd_en, reg_wr_en, irq_rd_strobe, fb_violation;
    logic [5:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;

    always #5 clk = ~clk;

    spi_fb_slave u_dut (
        .clk (clk), .rst (rst),
        .spi_sclk (sclk), .spi_cs_n (cs_n), .spi_mosi (mosi), .spi_miso (miso),
        .stat_mode (stat_mode), .stat_trx (stat_trx), .stat_rssi (stat_rssi),
        .stat_irq (stat_irq), .lqi_byte (lqi),
        .reg_rd_en (reg_rd_en), .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .irq_rd_strobe (irq_rd_strobe), .fb_violation (fb_violation)
    );

    // bench-side register space
    logic [7:0] regs [64];
    assign reg_rdata = regs[reg_addr];
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) regs[i] <= 8'(i * 7 + 1);
        end else if (reg_wr_en) begin
            regs[reg_addr] <= reg_wdata;
        end
    end

    // pulse counters, updated every clock
    int n_wr = 0, n_rd = 0, n_irq = 0, n_viol = 0;
    always @(posedge clk) begin
        if (!rst) begin
            if (reg_wr_en)     n_wr++;
            if (reg_rd_en)     n_rd++;
            if (irq_rd_strobe) n_irq++;
            if (fb_violation)  n_viol++;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] m_mem [128];

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer();
        rx_q.delete();
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int b = 0; b < tx_q.size(); b++) begin
            logic [7:0] r;
            for (int i = 7; i >= 0; i--) begin
                mosi = tx_q[b][i];
                repeat (4) @(negedge clk);
                r[i] = miso;
                sclk = 1'b1;
                repeat (4) @(negedge clk);
                sclk = 1'b0;
            end
            rx_q.push_back(r);
        end
        repeat (4) @(negedge clk);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        int base;
        rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; mosi = 1'b0;
        stat_mode = 2'd0; stat_trx = 8'h16; stat_rssi = 8'h2B; stat_irq = 8'h48;
        lqi = 8'hA5;
        for (int i = 0; i < 128; i++) m_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R1: reset state
        chk("R1 miso idle", int'(miso), 0);
        chk("R1 strobes", n_wr + n_rd + n_irq + n_viol, 0);
        tx_q = '{8'h20, 8'h00, 8'h00, 8'h00};
        xfer();
        chk("R1 status mode0", rx_q[0], 8'h00);
        chk("R1 length after reset", rx_q[1], 8'h00);
        chk("R8 lqi after empty frame", rx_q[2], 8'hA5);
        chk("R8 trailing zero", rx_q[3], 8'h00);

        // R3 status modes, R4 register read
        for (int m = 1; m < 4; m++) begin
            base = n_rd;
            stat_mode = 2'(m);
            tx_q = '{8'h81, 8'h00};
            xfer();
            chk("R3 status byte", rx_q[0], (m == 1) ? 8'h16 : (m == 2) ? 8'h2B : 8'h48);
            chk("R4 register read data", rx_q[1], 8'h08);
            chk("R4 read enable count", n_rd - base, 1);
        end
        stat_mode = 2'd0;

        // R5 register write, extra byte ignored
        base = n_wr;
        tx_q = '{8'hC5, 8'h3C, 8'h77};
        xfer();
        chk("R5 one write strobe", n_wr - base, 1);
        chk("R5 byte after write", rx_q[1], 8'h00);
        chk("R5 extra byte reply", rx_q[2], 8'h00);
        tx_q = '{8'h85, 8'h00};
        xfer();
        chk("R5 readback", rx_q[1], 8'h3C);

        // R6 interrupt-read strobe
        base = n_irq;
        tx_q = '{8'h8F, 8'h00};
        xfer();
        chk("R6 strobe on irq reg", n_irq - base, 1);
        chk("R6 irq reg data", rx_q[1], 8'(15 * 7 + 1));
        tx_q = '{8'h85, 8'h00};
        xfer();
        chk("R6 no strobe elsewhere", n_irq - base, 1);

        // R7 frame write, R8 frame read
        tx_q = '{8'h60, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
        xfer();
        for (int i = 0; i < 5; i++) m_mem[i] = 8'(8'h11 * (i + 1));
        tx_q = '{8'h20, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        xfer();
        chk("R7 stored length", rx_q[1], 8'h05);
        for (int i = 0; i < 5; i++) chk("R7 R8 payload", rx_q[2 + i], m_mem[i]);
        chk("R8 lqi", rx_q[7], 8'hA5);
        chk("R8 after lqi", rx_q[8], 8'h00);

        // R9 early termination
        tx_q = '{8'h20, 8'h00};
        xfer();
        chk("R9 partial length", rx_q[1], 8'h05);
        tx_q = '{8'h20, 8'h00, 8'h00};
        xfer();
        chk("R9 restart length", rx_q[1], 8'h05);
        chk("R9 restart payload", rx_q[2], 8'h11);

        // R10 addressed write with wrap, R11 addressed read
        base = n_viol;
        tx_q = '{8'h40, 8'h7E, 8'hAA, 8'hBB, 8'hCC};
        xfer();
        m_mem[126] = 8'hAA; m_mem[127] = 8'hBB; m_mem[0] = 8'hCC;
        chk("R10 no violation on wrap", n_viol - base, 0);
        tx_q = '{8'h00, 8'h7E, 8'h00, 8'h00, 8'h00};
        xfer();
        chk("R2 R11 read at start", rx_q[2], m_mem[126]);
        chk("R10 R11 incremented", rx_q[3], m_mem[127]);
        chk("R10 R11 wrapped", rx_q[4], m_mem[0]);
        tx_q = '{8'h00, 8'h00, 8'h00};
        xfer();
        chk("R11 address zero is payload", rx_q[2], 8'hCC);

        // R12 frame write overrun
        base = n_viol;
        tx_q = '{8'h60, 8'h7F};
        for (int i = 0; i < 128; i++) tx_q.push_back(8'(i) ^ 8'h5A);
        xfer();
        for (int i = 0; i < 127; i++) m_mem[i] = 8'(i) ^ 8'h5A;
        chk("R12 one violation", n_viol - base, 1);
        tx_q = '{8'h00, 8'h7E, 8'h00, 8'h00};
        xfer();
        chk("R12 last stored byte", rx_q[2], m_mem[126]);
        chk("R12 0x7F unchanged", rx_q[3], 8'hBB);
        tx_q = '{8'h20, 8'h00, 8'h00};
        xfer();
        chk("R7 full length", rx_q[1], 8'h7F);
        chk("R7 first payload", rx_q[2], m_mem[0]);

        report();
    end

endmodule